// File: doc/BRIEF.md
# Flash Status Pin Mode Controller

This block drives the active-low status pin of a flash-style memory controller. Out of reset the pin is a level ready/busy indicator. It is pulled low while the internal write state machine is busy. It stands high when the machine is ready or when an operation is suspended.

Software can write a one-byte configuration code to turn the pin into an interrupt source. In that case it idles high and drops low for a fixed number of clock cycles when an erase completes, when a program completes, or on either event. Bit 0 of the code enables the erase-complete pulse and bit 1 enables the program-complete pulse.

A configuration write is rejected if the code is invalid or if the device is busy or suspended. A rejected write leaves the mode unchanged and raises two error strobes that feed the status register. The strobes are the command-sequence error and the program/lock error.

Top module: `flash_status_pin`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the pin is high, both error strobes are low and the mode is level ready/busy.
- R2: In level mode the pin is registered one clock after the inputs are sampled. It is low when busy is high and suspended is low, and high otherwise.
- R3: An accepted code 00h returns the pin to level mode from any pulse mode.
- R4: Accepted codes 01h, 02h and 03h select the pulse modes. In these modes an enabled completion strobe sampled at edge k drives the pin low from edge k to edge k+PULSE_CYC. Code bit 0 enables the erase-done pulse and code bit 1 enables the program-done pulse. If both strobes arrive together, one pulse is produced.
- R5: In pulse modes the pin idles high and ignores busy, suspended and strobes of a kind the mode does not enable. In level mode the completion strobes have no effect on the pin.
- R6: The selected mode holds until a configuration write is accepted or reset is asserted. A rejected write never changes it.
- R7: A configuration write sampled while busy or suspended is high is rejected. Both error strobes are then high for exactly the next cycle.
- R8: Codes 04h to FFh are invalid. Writing one rejects the command and raises both error strobes for exactly the next cycle.
- R9: An enabled completion strobe that arrives while a pulse is running restarts the pulse at full width.
- R10: An accepted configuration write raises neither error strobe and cancels any pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Write state machine busy |
| susp_i | input | 1 | Operation suspended |
| erase_done_i | input | 1 | One-cycle erase completion strobe |
| prog_done_i | input | 1 | One-cycle program completion strobe |
| cfg_wr_i | input | 1 | Configuration command strobe |
| cfg_code_i | input | 8 | Configuration code |
| pin_n_o | output | 1 | Active-low status pin |
| seq_err_o | output | 1 | Command-sequence error strobe |
| prog_err_o | output | 1 | Program/lock error strobe |

## Verification
A wrong stored mode shows up at the pin within one cycle of the next busy change or completion strobe. The pin then either tracks busy when it should pulse, or pulses when it should track busy. A corrupted pulse counter appears as a low period that is too short or too long, and this can be seen at the edge where the pin should return high, PULSE_CYC cycles after the strobe. Faulty acceptance logic is visible one cycle after the configuration write, on the error strobes. It is visible again at the first later event, through the mode that was kept or changed.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
    localparam int CODE_W = 8;
    localparam int N_EVT  = 2;

    typedef enum logic [1:0] {
        PM_LEVEL = 2'b00,
        PM_ERASE = 2'b01,
        PM_PROG  = 2'b10,
        PM_BOTH  = 2'b11
    } pin_mode_e;

    typedef struct packed {
        pin_mode_e mode;
        logic      lvl;
        logic      seq_err;
        logic      prog_err;
    } pin_state_t;
endpackage

// File: rtl/fsp_cfg_decoder.sv
module fsp_cfg_decoder
    import fsp_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          wr_i,
    input  logic [CW-1:0] code_i,
    input  logic          busy_i,
    input  logic          susp_i,
    output logic          accept_o,
    output logic          reject_o,
    output pin_mode_e     mode_o
);
    localparam int MODE_W = 2;

    logic code_ok;
    logic idle;

    always_comb begin
        code_ok  = (code_i[CW-1:MODE_W] == '0);
        idle     = !busy_i && !susp_i;
        accept_o = wr_i && code_ok && idle;
        reject_o = wr_i && !(code_ok && idle);
        mode_o   = pin_mode_e'(code_i[MODE_W-1:0]);
    end
endmodule

// File: rtl/fsp_pulse_timer.sv
module fsp_pulse_timer #(
    parameter int WIDTH_CYC = 63
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic fire_i,
    output logic active_o
);
    localparam int CNT_W = $clog2(WIDTH_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WIDTH_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (fire_i) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign active_o = (cnt_q != '0);
endmodule

// File: rtl/flash_status_pin.sv
module flash_status_pin
    import fsp_pkg::*;
#(
    parameter int PULSE_CYC = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              susp_i,
    input  logic              erase_done_i,
    input  logic              prog_done_i,
    input  logic              cfg_wr_i,
    input  logic [CODE_W-1:0] cfg_code_i,
    output logic              pin_n_o,
    output logic              seq_err_o,
    output logic              prog_err_o
);
    pin_state_t st_d, st_q;

    logic      accept;
    logic      reject;
    pin_mode_e new_mode;
    logic      fire;
    logic      pulse_active;
    logic [N_EVT-1:0] evt;
    logic [N_EVT-1:0] evt_hit;
    logic [1:0] mode_q;

    fsp_cfg_decoder #(.CW(CODE_W)) dec_i (
        .wr_i     (cfg_wr_i),
        .code_i   (cfg_code_i),
        .busy_i   (busy_i),
        .susp_i   (susp_i),
        .accept_o (accept),
        .reject_o (reject),
        .mode_o   (new_mode)
    );

    // Event i is enabled by mode bit i: bit 0 erase, bit 1 program.
    assign evt = {prog_done_i, erase_done_i};

    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
        assign evt_hit[i] = evt[i] && st_q.mode[i];
    end

    assign fire = |evt_hit;

    fsp_pulse_timer #(.WIDTH_CYC(PULSE_CYC)) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .fire_i   (fire),
        .active_o (pulse_active)
    );

    always_comb begin
        st_d          = st_q;
        st_d.lvl      = !busy_i || susp_i;
        st_d.seq_err  = reject;
        st_d.prog_err = reject;
        if (accept) begin
            st_d.mode = new_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: PM_LEVEL, lvl: 1'b1, seq_err: 1'b0, prog_err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q     = st_q.mode;
    assign pin_n_o    = (st_q.mode == PM_LEVEL) ? st_q.lvl : !pulse_active;
    assign seq_err_o  = st_q.seq_err;
    assign prog_err_o = st_q.prog_err;
endmodule

// File: rtl/flash_status_pin_chk.sv
module flash_status_pin_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_i,
    input logic       susp_i,
    input logic       erase_done_i,
    input logic       prog_done_i,
    input logic       cfg_wr_i,
    input logic [7:0] cfg_code_i,
    input logic       pin_n_o,
    input logic       seq_err_o,
    input logic       prog_err_o,
    input logic [1:0] mode_q
);
    p_level_busy_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b00 && busy_i && !susp_i) |=> !pin_n_o);

    p_level_susp_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b00 && susp_i) |=> pin_n_o);

    p_erase_pulse_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[0] && erase_done_i && !cfg_wr_i) |=> !pin_n_o);

    p_prog_pulse_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1] && prog_done_i && !cfg_wr_i) |=> !pin_n_o);

    p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_i |=> $stable(mode_q));

    p_busy_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && (busy_i || susp_i)) |=> (seq_err_o && prog_err_o && $stable(mode_q)));

    p_bad_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && cfg_code_i > 8'h03) |=> (seq_err_o && prog_err_o && $stable(mode_q)));

    p_no_err_without_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_i |=> (!seq_err_o && !prog_err_o));

    p_accept_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !busy_i && !susp_i && cfg_code_i <= 8'h03)
        |=> (!seq_err_o && mode_q == $past(cfg_code_i[1:0]) && (mode_q == 2'b00 || pin_n_o)));
endmodule

bind flash_status_pin flash_status_pin_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_i),
    .susp_i       (susp_i),
    .erase_done_i (erase_done_i),
    .prog_done_i  (prog_done_i),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_code_i   (cfg_code_i),
    .pin_n_o      (pin_n_o),
    .seq_err_o    (seq_err_o),
    .prog_err_o   (prog_err_o),
    .mode_q       (mode_q)
);

// File: tb/flash_status_pin_tb_top.sv
module flash_status_pin_tb_top;
    localparam int W = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy_i = 1'b0, susp_i = 1'b0, erase_done_i = 1'b0, prog_done_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [7:0] cfg_code_i = 8'h00;
    logic       pin_n_o, seq_err_o, prog_err_o;

    int vectors = 0;
    int miscompares = 0;

    // reference state derived from the requirements
    int m_mode = 0;
    int m_cnt  = 0;
    bit m_lvl  = 1'b1;
    bit m_err  = 1'b0;

    always #2 clk = ~clk;

    flash_status_pin #(.PULSE_CYC(W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (busy_i),
        .susp_i       (susp_i),
        .erase_done_i (erase_done_i),
        .prog_done_i  (prog_done_i),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_code_i   (cfg_code_i),
        .pin_n_o      (pin_n_o),
        .seq_err_o    (seq_err_o),
        .prog_err_o   (prog_err_o)
    );

    task automatic cmp(input string tag, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        logic exp_pin;
        exp_pin = (m_mode == 0) ? m_lvl : (m_cnt == 0);
        cmp(tag, "pin_n_o", pin_n_o, exp_pin);
        cmp(tag, "seq_err_o", seq_err_o, m_err);
        cmp(tag, "prog_err_o", prog_err_o, m_err);
    endtask

    // drive after a falling edge, model the rising edge, check at the next falling edge
    task automatic step(input bit b, input bit s, input bit er, input bit pr,
                        input bit wr, input logic [7:0] code, input string tag);
        bit acc, trig;
        busy_i = b; susp_i = s; erase_done_i = er; prog_done_i = pr;
        cfg_wr_i = wr; cfg_code_i = code;
        acc  = wr && !b && !s && (code <= 8'h03);
        trig = (er && m_mode[0]) || (pr && m_mode[1]);
        @(posedge clk);
        if (acc)            m_cnt = 0;
        else if (trig)      m_cnt = W;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        if (acc) m_mode = int'(code[1:0]);
        m_lvl = !b || s;
        m_err = wr && !acc;
        @(negedge clk);
        busy_i = 1'b0; susp_i = 1'b0; erase_done_i = 1'b0; prog_done_i = 1'b0;
        cfg_wr_i = 1'b0; cfg_code_i = 8'h00;
        check_all(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 8'h00, tag);
    endtask

    task automatic run_events(input string tag);
        step(0, 0, 1, 0, 0, 8'h00, tag);
        idle(W + 1, tag);
        step(0, 0, 0, 1, 0, 8'h00, tag);
        idle(W + 1, tag);
        step(1, 0, 1, 1, 0, 8'h00, tag);
        idle(W + 1, tag);
        step(1, 0, 0, 0, 0, 8'h00, "R5");
        step(1, 1, 0, 0, 0, 8'h00, "R5");
        idle(1, "R5");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // level mode: all busy/suspend combinations, strobes ignored
        for (int v = 0; v < 16; v++) step(v[0], v[1], v[2], v[3], 0, 8'h00, "R2");
        step(0, 0, 1, 1, 0, 8'h00, "R5");

        // sweep every code from a pulse mode precondition
        for (int c = 0; c < 256; c++) begin
            step(0, 0, 0, 0, 1, 8'((c % 3) + 1), "R4");
            step(0, 0, 0, 0, 1, 8'(c), (c > 3) ? "R8" : (c == 0) ? "R3" : "R4");
            run_events((c > 3) ? "R6" : "R4");
        end

        // rejected while busy or suspended
        step(0, 0, 0, 0, 1, 8'h02, "R4");
        step(1, 0, 0, 0, 1, 8'h01, "R7");
        step(0, 1, 0, 0, 1, 8'h00, "R7");
        step(1, 1, 0, 0, 1, 8'h03, "R7");
        run_events("R6");

        // retrigger restarts the full width
        step(0, 0, 0, 0, 1, 8'h03, "R4");
        step(0, 0, 1, 0, 0, 8'h00, "R9");
        idle(2, "R9");
        step(0, 0, 0, 1, 0, 8'h00, "R9");
        idle(W - 1, "R9");
        step(0, 0, 1, 0, 0, 8'h00, "R9");
        idle(W + 1, "R9");

        // accepted write cancels a running pulse
        step(0, 0, 1, 0, 0, 8'h00, "R10");
        step(0, 0, 0, 0, 1, 8'h01, "R10");
        idle(W + 1, "R10");

        // reset in the middle of a pulse
        step(0, 0, 1, 0, 0, 8'h00, "R1");
        rst_n = 1'b0;
        m_mode = 0; m_cnt = 0; m_lvl = 1'b1; m_err = 1'b0;
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        step(0, 0, 1, 1, 0, 8'h00, "R1");
        step(1, 0, 0, 0, 0, 8'h00, "R1");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #1_000_000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule